// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block divides a 32-bit numerator by a 32-bit denominator one quotient bit per clock, using a restoring shift-and-subtract loop. A single-cycle start strobe, sampled while the unit is idle, captures both operands and a mode select that chooses two's-complement or unsigned interpretation. The busy output stays high for the whole operation. A one-clock valid pulse then presents the quotient together with a small set of condition flags.

In signed mode, one extra clock before the loop replaces both operands by their magnitudes and records the sign the result must take. When that sign is negative, one extra clock after the loop negates the quotient. A zero denominator skips the loop: the unit reports an error alongside valid after a single busy clock. The unit accepts one operation at a time. A start strobe seen while busy has no effect.

Top module: `iter_divider`

## Requirements
- R1: While reset is applied and after it is released, busy, valid and err are low and flags is 0.
- R2: A start strobe sampled while busy is low begins an operation, and busy is high on the following clock.
- R3: In unsigned mode with a nonzero denominator, the quotient at valid equals floor(numerator/denominator) of the unsigned operands, and busy stays high for exactly 32 clocks.
- R4: In signed mode with a nonzero denominator, the quotient is the magnitude quotient, truncated toward zero, negated when exactly one operand is negative. Busy lasts 33 clocks when the result sign is positive and 34 clocks when it is negative, including a negative result of magnitude 0.
- R5: A signed division of 0x80000000 by 0xFFFFFFFF returns 0x80000000 with err low.
- R6: Busy falls on the same clock that valid rises. Busy and valid are never high together, and valid is high for exactly one clock per operation.
- R7: While valid is high, flags[0] is 1 exactly when the quotient is 0, flags[1] equals quotient bit 31, and flags[3:2] are 0. While valid is low, flags is 0.
- R8: A zero denominator, in either mode, keeps busy high for exactly one clock and then raises err together with valid, with a quotient of 0. Err is low on every completion with a nonzero denominator.
- R9: Start strobes sampled while busy is high change neither the result nor the latency of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe, sampled while idle |
| signedOp | input | 1 | 1: two's-complement operands, 0: unsigned |
| numer | input | 32 | Numerator |
| denom | input | 32 | Denominator |
| busy | output | 1 | Operation in progress |
| valid | output | 1 | One-clock result pulse |
| err | output | 1 | Divide-by-zero, high only with valid |
| quotient | output | 32 | Quotient, meaningful while valid |
| flags | output | 4 | bit0 zero, bit1 negative, bits 3:2 zero; 0 when valid is low |

## Verification
A wrong iteration count or a missed state transition shows up as a busy window of the wrong length, and the bench measures that window to the clock for every mode and sign combination. A wrong compare, subtract or shift corrupts the quotient bits and is caught on the single clock where valid is high. A wrong sign record or a misplaced negation shows up first as an off-by-one latency and then as a wrong quotient sign, and the flags confirm the quotient bit 31 on that same clock. Operands chosen at the extremes (all ones, the most negative value, a magnitude quotient of 0 with a negative sign, a zero denominator) push the datapath to its edges.

// File: rtl/iter_div_pkg.sv
package iter_div_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ABS   = 3'd1,
    ST_LOOP  = 3'd2,
    ST_NEG   = 3'd3,
    ST_DZERO = 3'd4
  } divState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic absFix;
    logic step;
    logic negate;
  } dpCtl_t;

endpackage

// File: rtl/iter_div_ctrl.sv
module iter_div_ctrl
  import iter_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   signedOp,
  input  logic   denomZero,
  input  logic   resultNeg,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   valid,
  output logic   err
);

  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_ITER = CW'(W - 1);

  divState_t state, nextState;
  logic [CW-1:0] iterCnt;
  logic lastIter;

  assign lastIter = (iterCnt == LAST_ITER);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (denomZero)     nextState = ST_DZERO;
          else if (signedOp) nextState = ST_ABS;
          else               nextState = ST_LOOP;
        end
      end
      ST_ABS:   nextState = ST_LOOP;
      ST_LOOP:  if (lastIter) nextState = resultNeg ? ST_NEG : ST_IDLE;
      ST_NEG:   nextState = ST_IDLE;
      ST_DZERO: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.load   = (state == ST_IDLE) && start;
    ctl.absFix = (state == ST_ABS);
    ctl.step   = (state == ST_LOOP);
    ctl.negate = (state == ST_NEG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      valid   <= 1'b0;
      err     <= 1'b0;
    end else begin
      state <= nextState;
      valid <= (state != ST_IDLE) && (nextState == ST_IDLE);
      err   <= (state == ST_DZERO);
      if (ctl.load)      iterCnt <= '0;
      else if (ctl.step) iterCnt <= iterCnt + 1'b1;
    end
  end

  AST_BUSY_VALID_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && valid)); // R6

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R6

  AST_FALL_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> valid); // R6

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2

  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    err |-> valid); // R8

endmodule

// File: rtl/iter_div_dpath.sv
module iter_div_dpath
  import iter_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  dpCtl_t       ctl,
  input  logic [W-1:0] numer,
  input  logic [W-1:0] denom,
  output logic         denomZero,
  output logic         resultNeg,
  output logic [W-1:0] quot
);

  localparam int DW = 2 * W - 1;
  localparam int SH = W - 1;

  logic [W-1:0]  remReg;
  logic [DW-1:0] dvsReg;
  logic          fits;

  assign denomZero = (denom == '0);
  assign fits      = (dvsReg <= {{SH{1'b0}}, remReg});

  always_ff @(posedge clk) begin
    if (rst) begin
      remReg    <= '0;
      dvsReg    <= '0;
      quot      <= '0;
      resultNeg <= 1'b0;
    end else if (ctl.load) begin
      remReg    <= numer;
      dvsReg    <= {denom, {SH{1'b0}}};
      quot      <= '0;
      resultNeg <= 1'b0;
    end else if (ctl.absFix) begin
      if (remReg[W-1])    remReg <= -remReg;
      if (dvsReg[DW-1])   dvsReg[DW-1:SH] <= -dvsReg[DW-1:SH];
      resultNeg <= remReg[W-1] ^ dvsReg[DW-1];
    end else if (ctl.step) begin
      if (fits) begin
        remReg <= remReg - dvsReg[W-1:0];
        quot   <= {quot[W-2:0], 1'b1};
      end else begin
        quot   <= {quot[W-2:0], 1'b0};
      end
      dvsReg <= dvsReg >> 1;
    end else if (ctl.negate) begin
      quot <= -quot;
    end
  end

  AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (ctl.step && fits) |=> (remReg < $past(remReg))); // R3

  AST_NEG_AFTER_SIGN: assert property (@(posedge clk) disable iff (rst)
    ctl.negate |-> resultNeg); // R4

endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import iter_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         signedOp,
  input  logic [W-1:0] numer,
  input  logic [W-1:0] denom,
  output logic         busy,
  output logic         valid,
  output logic         err,
  output logic [W-1:0] quotient,
  output logic [3:0]   flags
);

  dpCtl_t ctl;
  logic   denomZero;
  logic   resultNeg;

  iter_div_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .signedOp  (signedOp),
    .denomZero (denomZero),
    .resultNeg (resultNeg),
    .ctl       (ctl),
    .busy      (busy),
    .valid     (valid),
    .err       (err)
  );

  iter_div_dpath #(.W(W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .numer     (numer),
    .denom     (denom),
    .denomZero (denomZero),
    .resultNeg (resultNeg),
    .quot      (quotient)
  );

  assign flags = valid ? {2'b00, quotient[W-1], (quotient == '0)} : 4'b0000;

endmodule

// File: tb/sim_iter_divider.sv
`timescale 1ns/1ps
module sim_iter_divider;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        signedOp = 1'b0;
  logic [31:0] numer = '0;
  logic [31:0] denom = '0;
  logic        busy, valid, err;
  logic [31:0] quotient;
  logic [3:0]  flags;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  iter_divider u0 (
    .clk(clk), .rst(rst), .start(start), .signedOp(signedOp),
    .numer(numer), .denom(denom), .busy(busy), .valid(valid),
    .err(err), .quotient(quotient), .flags(flags)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !valid && !err && flags == 4'd0, "R1", "outputs in reset",
          {28'd0, busy, valid, err, |flags}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !valid && !err && flags == 4'd0, "R1", "outputs after reset",
          {28'd0, busy, valid, err, |flags}, 32'd0);
  endtask

  // one operation; disturb pulses start with other operands while busy (R9)
  task automatic runDiv(input logic [31:0] n, input logic [31:0] d, input bit sgn,
                        input string req, input bit disturb);
    logic [31:0] mn, md, expQ;
    bit neg, expErr, overlap;
    int expCycles, cycles;
    if (d == 0) begin
      expQ = 0; expErr = 1; expCycles = 1;
    end else begin
      mn = (sgn && n[31]) ? -n : n;
      md = (sgn && d[31]) ? -d : d;
      expQ = mn / md;
      neg = sgn && (n[31] ^ d[31]);
      if (neg) expQ = -expQ;
      expErr = 0;
      expCycles = 32 + int'(sgn) + int'(neg);
    end
    @(negedge clk);
    numer = n; denom = d; signedOp = sgn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R2", "busy after start", {31'd0, busy}, 32'd1);
    cycles = 0; overlap = 0;
    while (busy && cycles < 60) begin
      cycles++;
      if (disturb && cycles < expCycles) begin
        start = 1'b1; numer = ~n; denom = 32'd1; signedOp = ~sgn;
      end else begin
        start = 1'b0; numer = n; denom = d; signedOp = sgn;
      end
      @(negedge clk);
      if (busy && valid) overlap = 1;
    end
    start = 1'b0;
    check(!overlap, "R6", "busy and valid overlap", {31'd0, overlap}, 32'd0);
    check(cycles == expCycles, req, "busy length", cycles, expCycles);
    check(valid, "R6", "valid as busy falls", {31'd0, valid}, 32'd1);
    check(err == expErr, expErr ? "R8" : req, "err", {31'd0, err}, {31'd0, expErr});
    check(quotient == expQ, req, "quotient", quotient, expQ);
    check(flags == {2'b00, expQ[31], expQ == 0}, "R7", "flags at valid",
          {28'd0, flags}, {28'd0, 2'b00, expQ[31], expQ == 0});
    @(negedge clk);
    check(!valid && !busy, "R6", "valid one clock", {30'd0, valid, busy}, 32'd0);
    check(flags == 4'd0, "R7", "flags quiet", {28'd0, flags}, 32'd0);
  endtask

  task automatic testUnsigned();
    runDiv(32'd100, 32'd7, 1'b0, "R3", 1'b0);
    runDiv(32'hFFFF_FFFF, 32'd1, 1'b0, "R3", 1'b0);
    runDiv(32'd5, 32'd10, 1'b0, "R3", 1'b0);
    runDiv(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3", 1'b0);
    runDiv(32'hFFFF_FFF6, 32'd3, 1'b0, "R3", 1'b0);
  endtask

  task automatic testSigned();
    runDiv(-32'sd100, 32'd7, 1'b1, "R4", 1'b0);
    runDiv(32'd100, -32'sd7, 1'b1, "R4", 1'b0);
    runDiv(-32'sd100, -32'sd7, 1'b1, "R4", 1'b0);
    runDiv(32'd7, -32'sd100, 1'b1, "R4", 1'b0);
    runDiv(32'd1000, 32'd33, 1'b1, "R4", 1'b0);
  endtask

  task automatic testMostNegative();
    runDiv(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R5", 1'b0);
  endtask

  task automatic testZeroDenom();
    runDiv(32'd1234, 32'd0, 1'b0, "R8", 1'b0);
    runDiv(32'h8000_0000, 32'd0, 1'b1, "R8", 1'b0);
  endtask

  task automatic testBusyWrites();
    runDiv(32'd99999, 32'd13, 1'b0, "R9", 1'b1);
    runDiv(-32'sd99999, 32'd13, 1'b1, "R9", 1'b1);
  endtask

  initial begin
    testReset();
    testUnsigned();
    testSigned();
    testMostNegative();
    testZeroDenom();
    testBusyWrites();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule